// File: doc/BRIEF.md
# PRBS7 Pattern Source and Bit-Error Checker

This block is a built-in test function for a one-bit serial data path. It runs in one of two modes. As a source, it drives a seven-stage maximal-length pseudo-random sequence onto the serial output, one bit per clock. As a checker, it watches the serial input, predicts each incoming bit from the seven bits before it, and marks every mismatch on the serial output with a short two-pulse burst. Only one mode can be active at a time. When no valid mode is selected, the serial input passes straight to the serial output.

Software selects the mode through a small write port. The port carries two three-bit fields and a start bit. The first field acts as an arming key. The second field picks source or checker. The source does not emit anything until it sees a falling edge on the start bit, that is, a write of 0 while the stored value is 1. The checker synchronises itself from the incoming stream, so it needs no trigger.

Top module: `prbs7_test_unit`

## Requirements
- R1: After reset, both fields and the start bit read as zero, no test mode is active, and `ser_out` equals `ser_in` in the same cycle.
- R2: The source and the checker are never active together: the source running and the checker holding any received history never coincide.
- R3: A test mode is active only while the arming field holds 5. With any other arming value, `ser_out` equals `ser_in`, whatever the select field holds.
- R4: With arming at 5, a select value of 1 picks the source and a select value of 4 picks the checker. Any other select value gives pass-through.
- R5: In source mode, a write that stores 0 into the start bit while it holds 1 reloads the seven-stage register with all ones. The first pattern bit appears on `ser_out` in the second cycle after that write's clock edge. A write of 1, or a write of 0 over 0, starts nothing. Before the first trigger, `ser_out` is 0.
- R6: Once started, the source emits one bit per clock. The first seven bits are 1, and each later bit equals the XOR of the bits seven and six positions earlier (polynomial x^7 + x^6 + 1, period 127).
- R7: In checker mode, each received bit after the first seven since the mode was entered is flagged as an error when it differs from the XOR of the bits received seven and six positions earlier. The first seven bits are never flagged.
- R8: Each flagged error makes `ser_out` go high for one cycle, low for one cycle, then high for one cycle. At least one low cycle follows before the next burst. The first high cycle comes two cycles after the clock edge that sampled the bad bit.
- R9: Errors flagged while a burst is in progress are queued, up to 15, and each gets its own burst later, so the number of high cycles is twice the number of flagged errors.
- R10: In checker mode, `ser_out` carries only error bursts. It stays low when the input follows the sequence rule.
- R11: Leaving a test mode clears all of its state. When source mode is entered again, `ser_out` stays 0 until a new start trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_arm | input | 3 | Arming field; 5 enables testing |
| cfg_sel | input | 3 | Mode select: 1 source, 4 checker |
| cfg_start | input | 1 | Start bit; a stored 1-to-0 change triggers the source |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Pattern, error bursts, or pass-through data |

## Verification
In checker mode, a new error can be flagged in the same cycle that the burst shaper is busy with an earlier burst. This happens because one corrupted input bit produces three flags, the last two only one bit apart. The bench corrupts a single bit inside a clean sequence and compares the exact cycle-by-cycle trace of `ser_out` against a precomputed mask. That mask includes the queued burst that follows the collision. Random corruption over long streams is then judged by checking that the high-cycle count equals twice the error count from an independent model of the sequence rule.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;

    localparam int SEQ_W     = 7;
    localparam int TAP_HI    = 7;
    localparam int TAP_LO    = 6;
    localparam int FLD_W     = 3;
    localparam int FILL_W    = $clog2(SEQ_W + 1);

    localparam logic [FLD_W-1:0] ARM_KEY  = 3'd5;
    localparam logic [FLD_W-1:0] SEL_SRC  = 3'd1;
    localparam logic [FLD_W-1:0] SEL_CHK  = 3'd4;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_SRC = 2'd1,
        MODE_CHK = 2'd2
    } test_mode_e;

    typedef enum logic [2:0] {
        BST_IDLE = 3'd0,
        BST_HI1  = 3'd1,
        BST_LO   = 3'd2,
        BST_HI2  = 3'd3,
        BST_GAP  = 3'd4
    } burst_st_e;

endpackage

// File: rtl/prbs7_ctrl.sv
module prbs7_ctrl
    import prbs7_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [FLD_W-1:0] arm_i,
    input  logic [FLD_W-1:0] sel_i,
    input  logic             start_i,
    output test_mode_e       mode_o,
    output logic             trig_o
);

    typedef struct packed {
        logic [FLD_W-1:0] arm;
        logic [FLD_W-1:0] sel;
        logic             start;
        logic             trig;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d      = q;
        d.trig = 1'b0;
        if (wr_i) begin
            d.arm   = arm_i;
            d.sel   = sel_i;
            d.start = start_i;
            d.trig  = q.start & ~start_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mode_o = MODE_OFF;
        if (q.arm == ARM_KEY) begin
            if (q.sel == SEL_SRC)      mode_o = MODE_SRC;
            else if (q.sel == SEL_CHK) mode_o = MODE_CHK;
        end
    end

    assign trig_o = q.trig;

    // R5: a trigger only follows a write that stored zero
    assert_trig_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.trig) |-> (!q.start && $past(q.start)));

endmodule

// File: rtl/prbs7_gen.sv
module prbs7_gen
    import prbs7_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic trig_i,
    output logic bit_o,
    output logic run_o
);

    typedef struct packed {
        logic [SEQ_W-1:0] lfsr;
        logic             run;
    } gen_t;

    gen_t q, d;
    logic fb;

    assign fb = q.lfsr[TAP_HI-1] ^ q.lfsr[TAP_LO-1];

    always_comb begin
        d = q;
        if (!en_i) begin
            d.lfsr = '1;
            d.run  = 1'b0;
        end else if (trig_i) begin
            d.lfsr = '1;
            d.run  = 1'b1;
        end else if (q.run) begin
            d.lfsr = {q.lfsr[SEQ_W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lfsr <= '1;
            q.run  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bit_o = q.run & q.lfsr[SEQ_W-1];
    assign run_o = q.run;

    assert_seed_on_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && trig_i) |=> (q.run && q.lfsr == {SEQ_W{1'b1}}));

    assert_never_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.lfsr != '0));

    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !bit_o);

endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
    import prbs7_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic din_i,
    output logic err_o,
    output logic busy_o
);

    typedef struct packed {
        logic [SEQ_W-1:0]  hist;
        logic [FILL_W-1:0] fill;
        logic              err;
    } chk_t;

    localparam logic [FILL_W-1:0] FULL = FILL_W'(SEQ_W);

    chk_t q, d;
    logic pred;

    assign pred = q.hist[TAP_HI-1] ^ q.hist[TAP_LO-1];

    always_comb begin
        d = '0;
        if (en_i) begin
            d.hist = {q.hist[SEQ_W-2:0], din_i};
            d.fill = (q.fill == FULL) ? FULL : q.fill + 1'b1;
            d.err  = (q.fill == FULL) && (din_i != pred);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err_o  = q.err;
    assign busy_o = (q.fill != '0);

    assert_cleared_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!err_o && !busy_o));

endmodule

// File: rtl/prbs7_burst.sv
module prbs7_burst
    import prbs7_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic err_i,
    output logic pulse_o
);

    localparam logic [CNT_W:0] CAP = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        burst_st_e        st;
        logic [CNT_W-1:0] pend;
    } bst_t;

    bst_t q, d;
    logic [CNT_W:0] avail;
    logic [CNT_W:0] left;

    always_comb begin
        avail = {1'b0, q.pend} + {{CNT_W{1'b0}}, err_i};
        left  = avail;
        d     = q;
        case (q.st)
            BST_IDLE, BST_GAP: begin
                if (avail != '0) begin
                    d.st = BST_HI1;
                    left = avail - 1'b1;
                end else begin
                    d.st = BST_IDLE;
                end
            end
            BST_HI1: d.st = BST_LO;
            BST_LO:  d.st = BST_HI2;
            BST_HI2: d.st = BST_GAP;
            default: d.st = BST_IDLE;
        endcase
        d.pend = (left > CAP) ? CAP[CNT_W-1:0] : left[CNT_W-1:0];
        if (!en_i) begin
            d.st   = BST_IDLE;
            d.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= BST_IDLE;
            q.pend <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_o = (q.st == BST_HI1) || (q.st == BST_HI2);

    assert_gap_inside_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.st == BST_HI1) |=> !pulse_o);

    assert_second_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.st == BST_LO) |=> pulse_o);

    assert_low_after_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BST_HI2) |=> !pulse_o);

endmodule

// File: rtl/prbs7_test_unit.sv
module prbs7_test_unit
    import prbs7_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_arm,
    input  logic [2:0] cfg_sel,
    input  logic       cfg_start,
    input  logic       ser_in,
    output logic       ser_out
);

    test_mode_e mode;
    logic trig, gen_bit, gen_run, chk_err, chk_busy, burst;

    prbs7_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .arm_i   (cfg_arm),
        .sel_i   (cfg_sel),
        .start_i (cfg_start),
        .mode_o  (mode),
        .trig_o  (trig)
    );

    prbs7_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mode == MODE_SRC),
        .trig_i (trig),
        .bit_o  (gen_bit),
        .run_o  (gen_run)
    );

    prbs7_chk u_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mode == MODE_CHK),
        .din_i  (ser_in),
        .err_o  (chk_err),
        .busy_o (chk_busy)
    );

    prbs7_burst #(.CNT_W(CNT_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mode == MODE_CHK),
        .err_i   (chk_err),
        .pulse_o (burst)
    );

    always_comb begin
        case (mode)
            MODE_SRC: ser_out = gen_bit;
            MODE_CHK: ser_out = burst;
            default:  ser_out = ser_in;
        endcase
    end

    assert_one_function_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_run && chk_busy));

endmodule

// File: tb/prbs7_test_unit_tb.sv
module prbs7_test_unit_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_arm = '0;
    logic [2:0] cfg_sel = '0;
    logic cfg_start = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic tx [0:1023];
    logic cl [0:1023];
    logic hi [0:1023];
    logic g  [0:255];

    always #4 clk = ~clk;

    prbs7_test_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_arm(cfg_arm),
        .cfg_sel(cfg_sel), .cfg_start(cfg_start), .ser_in(ser_in), .ser_out(ser_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_err = n_err + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] a, input logic [2:0] s, input logic st);
        cfg_wr = 1'b1; cfg_arm = a; cfg_sel = s; cfg_start = st;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Checker session: drives n bits; returns errors predicted by the sequence rule
    task automatic det_stream(input int n, input int flip_at, input int div, output int exp_err, output int highs);
        logic [6:0] seed;
        seed = 7'($urandom());
        exp_err = 0;
        highs = 0;
        for (int i = 0; i < n; i++) begin
            logic f;
            cl[i] = (i < 7) ? seed[i] : (cl[i-7] ^ cl[i-6]);
            f = (i == flip_at) || (div > 0 && i < n - 100 && ($urandom() % div) == 0);
            tx[i] = cl[i] ^ f;
            if (i >= 7 && (tx[i] != (tx[i-7] ^ tx[i-6]))) exp_err++;
            ser_in = tx[i];
            @(posedge clk);
            @(negedge clk);
            hi[i] = ser_out;
            if (ser_out) highs++;
        end
    endtask

    initial begin
        int e, h;
        logic [63:0] act, exp;
        void'($urandom(32'd7351));
        for (int i = 0; i < 256; i++) g[i] = (i < 7) ? 1'b1 : (g[i-7] ^ g[i-6]);

        // R1: reset state, pass-through
        repeat (3) @(negedge clk);
        ser_in = 1'b1; #1;
        check("R1 pass-through in reset", 64'(ser_out), 64'd1);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ser_in = 1'($urandom()); #1;
            check("R1 pass-through after reset", 64'(ser_out), 64'(ser_in));
        end

        // R3 / R4: invalid codes give pass-through
        for (int i = 0; i < 30; i++) begin
            logic [2:0] a, s;
            a = 3'($urandom()); s = 3'($urandom());
            if (a == 3'd5 && (s == 3'd1 || s == 3'd4)) s = 3'd2;
            write_cfg(a, s, 1'b0);
            ser_in = 1'($urandom()); #1;
            check(a == 3'd5 ? "R4 bad select pass-through" : "R3 bad arm pass-through", 64'(ser_out), 64'(ser_in));
            ser_in = ~ser_in; #1;
            check("R3 pass-through follows input", 64'(ser_out), 64'(ser_in));
        end
        write_cfg(3'd4, 3'd1, 1'b1);
        write_cfg(3'd4, 3'd1, 1'b0);
        ser_in = 1'b1; #1;
        check("R3 arm 4 with trigger still passes", 64'(ser_out), 64'd1);

        // R5: source idle before trigger, 0->1 and 0->0 writes do nothing
        write_cfg(3'd5, 3'd1, 1'b0);
        ser_in = 1'b1;
        check("R5 source low before trigger", 64'(ser_out), 64'd0);
        write_cfg(3'd5, 3'd1, 1'b0);
        @(negedge clk);
        check("R5 write 0 over 0 no start", 64'(ser_out), 64'd0);
        write_cfg(3'd5, 3'd1, 1'b1);
        @(negedge clk);
        check("R5 write 1 no start", 64'(ser_out), 64'd0);

        // R5 / R6: trigger then sequence
        write_cfg(3'd5, 3'd1, 1'b0);
        check("R5 not yet running on trigger edge", 64'(ser_out), 64'd0);
        act = '0; exp = '0;
        for (int i = 0; i < 140; i++) begin
            @(posedge clk); @(negedge clk);
            if (ser_out !== g[i]) begin
                check("R6 source sequence", 64'(ser_out), 64'(g[i]));
            end else n_chk++;
        end

        // R5: re-trigger mid-run restarts from all ones
        write_cfg(3'd5, 3'd1, 1'b1);
        repeat (5) @(negedge clk);
        write_cfg(3'd5, 3'd1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            act[i] = ser_out; exp[i] = g[i];
        end
        check("R5 restart reseeds", act & 64'hFFFFF, exp & 64'hFFFFF);

        // R11: leave and re-enter source mode, output stays low
        write_cfg(3'd0, 3'd0, 1'b0);
        write_cfg(3'd5, 3'd1, 1'b0);
        act = '0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); act[i] = ser_out;
        end
        check("R11 source cleared on re-entry", act, 64'd0);

        // R7 / R10: clean stream, random seed, no bursts
        write_cfg(3'd0, 3'd0, 1'b0);
        write_cfg(3'd5, 3'd4, 1'b0);
        det_stream(200, -1, 0, e, h);
        check("R7 R10 clean stream no flags", 64'(h), 64'd0);
        check("R7 model agrees clean", 64'(e), 64'd0);

        // R8 / R9: single corrupted bit, three flags, exact trace
        write_cfg(3'd0, 3'd0, 1'b0);
        write_cfg(3'd5, 3'd4, 1'b0);
        det_stream(60, 30, 0, e, h);
        act = '0; exp = '0;
        for (int j = 0; j < 50; j++) act[j] = hi[j];
        exp[31] = 1; exp[33] = 1; exp[37] = 1; exp[39] = 1; exp[41] = 1; exp[43] = 1;
        check("R8 R9 burst trace with queued flag", act, exp);
        check("R9 three flags for one bad bit", 64'(e), 64'd3);

        // R7: corruption inside first seven bits is not flagged at once
        write_cfg(3'd0, 3'd0, 1'b0);
        write_cfg(3'd5, 3'd4, 1'b0);
        det_stream(60, 3, 0, e, h);
        check("R7 priming bits never flagged", 64'(h), 64'(2 * e));

        // R9: random corruption, counts must match
        for (int k = 0; k < 4; k++) begin
            write_cfg(3'd0, 3'd0, 1'b0);
            write_cfg(3'd5, 3'd4, 1'b0);
            det_stream(800, -1, 60, e, h);
            check("R9 high cycles equal twice flags", 64'(h), 64'(2 * e));
        end

        // R2 / R11: switch checker to source mid-stream
        write_cfg(3'd5, 3'd1, 1'b1);
        write_cfg(3'd5, 3'd1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
            act[i] = ser_out; exp[i] = g[i];
        end
        check("R2 source after checker", act & 64'h3FF, exp & 64'h3FF);

        write_cfg(3'd0, 3'd0, 1'b0);
        ser_in = 1'b0; #1;
        check("R1 back to pass-through", 64'(ser_out), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule